// File: doc/BRIEF.md
# Set/Clear Inter-Core Mailbox Bank

This block holds a bank of 32-bit message words that cores use to signal one another. There are four cores and four mailboxes per core, sixteen words in all. A writer never overwrites a word. A write to the set window ORs its data into the word. A write to the clear window removes every bit that is one in the data. A core that owns a mailbox reads the word back through the clear window and then acknowledges it by writing those same bits to the clear window.

Any word that holds a non-zero value is pending. Each core has an 8-bit mask register with one IRQ enable and one FIQ enable per mailbox. The mask register turns the pending words of that core into one IRQ request line and one FIQ request line. These request lines go to an interrupt router, which is outside this block.

The register bus is 32 bits wide and word-aligned. Every access completes in one cycle. A write takes effect at the clock edge on which it is presented. A read returns its data in the same cycle as the request.

Top module: `mbx_bank`

## Requirements
- R1: After reset, every mailbox word and every mask register reads as zero, and all IRQ and FIQ request outputs are low.
- R2: A write to byte address 0x80 + 4*k (k from 0 to 15) ORs the write data into mailbox k. Bits that are already set stay set.
- R3: A write to byte address 0xC0 + 4*k clears each bit of mailbox k that is 1 in the write data. All other bits of the word keep their value.
- R4: A read of 0xC0 + 4*k returns the content of mailbox k. A read of any address in the set window (0x80 to 0xBF) returns zero.
- R5: Mailbox k belongs to core k/4 as its mailbox number k%4. A mailbox drives only the request outputs of its own core.
- R6: The mask register of core c is at byte address 0x50 + 4*c. It stores write-data bits 7:0 and reads back with bits 31:8 equal to zero.
- R7: irq_req[c] is high when some mailbox n of core c is non-zero, bit n of its mask is 1, and bit n+4 of its mask is 0.
- R8: fiq_req[c] is high when some mailbox n of core c is non-zero and bit n+4 of its mask is 1. A mailbox with its FIQ enable set never raises the IRQ line, whatever its IRQ enable holds.
- R9: An address that is not word-aligned (bits 1:0 not zero) or that lies outside the three windows has no effect on a write and returns zero on a read.
- R10: The request outputs reflect a write from the clock edge that accepts it. They are valid at the next falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of bus_rd |
| irq_req | output | 4 | Per-core IRQ request |
| fiq_req | output | 4 | Per-core FIQ request |

## Verification
A word that is corrupted inside the bank shows up at the next read of its clear-window address. If that mailbox is enabled, it also shows up on its core's request line half a cycle after the write edge. A decode slip has two visible effects: the written bits land in a neighbouring word or core, and a request line toggles for the wrong core. A precedence error shows as IRQ and FIQ both asserted for a mailbox that is set only for FIQ. The bench compares both request vectors after every access, and it reads back a random word after every access. A wrong state therefore shows within one or two bus operations.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int CORES       = 4;
  localparam int BOX_PER_CPU = 4;
  localparam int WORD_W      = 32;
  localparam int ADDR_W      = 8;

  localparam int MASK_BASE   = 'h50;
  localparam int SET_BASE    = 'h80;
  localparam int CLR_BASE    = 'hC0;

  // Next value of a word after a set pattern and then a clear pattern.
  function automatic logic [WORD_W-1:0] merge_word(
    input logic [WORD_W-1:0] cur,
    input logic [WORD_W-1:0] setm,
    input logic [WORD_W-1:0] clrm
  );
    return (cur | setm) & ~clrm;
  endfunction
endpackage

// File: rtl/mbx_word.sv
module mbx_word #(
  parameter int W = mbx_pkg::WORD_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_en,
  input  logic         clr_en,
  input  logic [W-1:0] data,
  output logic [W-1:0] val,
  output logic         pend
);
  logic [W-1:0] set_m, clr_m;

  assign set_m = set_en ? data : '0;
  assign clr_m = clr_en ? data : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) val <= '0;
    else        val <= (val | set_m) & ~clr_m;
  end

  assign pend = |val;

  // R2
  set_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_en && !clr_en |=> val == ($past(val) | $past(data)));
  // R3
  clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> (val & $past(data)) == '0);
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !set_en && !clr_en |=> $stable(val));
endmodule

// File: rtl/mbx_core_route.sv
module mbx_core_route #(
  parameter int MBN = mbx_pkg::BOX_PER_CPU,
  localparam int CW = 2 * MBN
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ctl_we,
  input  logic [CW-1:0]  ctl_wdata,
  input  logic [MBN-1:0] pend,
  output logic [CW-1:0]  ctl_q,
  output logic           irq,
  output logic           fiq
);
  function automatic logic fiq_of(input logic [MBN-1:0] p, input logic [CW-1:0] m);
    return |(p & m[CW-1:MBN]);
  endfunction

  function automatic logic irq_of(input logic [MBN-1:0] p, input logic [CW-1:0] m);
    return |(p & m[MBN-1:0] & ~m[CW-1:MBN]);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_we) ctl_q <= ctl_wdata;
  end

  assign irq = irq_of(pend, ctl_q);
  assign fiq = fiq_of(pend, ctl_q);

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend == '0 |-> !irq && !fiq);
  // R8
  no_fiq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[CW-1:MBN] == '0 |-> !fiq);
  // R6
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> ctl_q == $past(ctl_wdata));
endmodule

// File: rtl/mbx_bank.sv
module mbx_bank #(
  parameter int NUM_CORES   = mbx_pkg::CORES,
  parameter int MB_PER_CORE = mbx_pkg::BOX_PER_CPU,
  parameter int DATA_W      = mbx_pkg::WORD_W,
  parameter int ADDR_W      = mbx_pkg::ADDR_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic [NUM_CORES-1:0] irq_req,
  output logic [NUM_CORES-1:0] fiq_req
);
  localparam int N_MB   = NUM_CORES * MB_PER_CORE;
  localparam int CTRL_W = 2 * MB_PER_CORE;
  localparam int IDX_W  = (N_MB > 1) ? $clog2(N_MB) : 1;
  localparam int CIDX_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;

  function automatic logic win_hit(input logic [ADDR_W-1:0] a, input int base, input int cnt);
    int ai;
    ai = int'(a);
    return (a[1:0] == 2'b00) && (ai >= base) && (ai < base + 4 * cnt);
  endfunction

  function automatic int win_idx(input logic [ADDR_W-1:0] a, input int base);
    return (int'(a) - base) >>> 2;
  endfunction

  logic              set_hit, clr_hit, ctl_hit;
  logic [IDX_W-1:0]  set_idx, clr_idx;
  logic [CIDX_W-1:0] ctl_idx;

  assign set_hit = win_hit(bus_addr, mbx_pkg::SET_BASE, N_MB);
  assign clr_hit = win_hit(bus_addr, mbx_pkg::CLR_BASE, N_MB);
  assign ctl_hit = win_hit(bus_addr, mbx_pkg::MASK_BASE, NUM_CORES);
  assign set_idx = IDX_W'(win_idx(bus_addr, mbx_pkg::SET_BASE));
  assign clr_idx = IDX_W'(win_idx(bus_addr, mbx_pkg::CLR_BASE));
  assign ctl_idx = CIDX_W'(win_idx(bus_addr, mbx_pkg::MASK_BASE));

  logic [DATA_W-1:0] mb_val [N_MB];
  logic [N_MB-1:0]   mb_pend;
  logic [CTRL_W-1:0] ctl_q  [NUM_CORES];

  for (genvar k = 0; k < N_MB; k++) begin : g_box
    logic set_en_k, clr_en_k;
    assign set_en_k = bus_wr && set_hit && (set_idx == IDX_W'(k));
    assign clr_en_k = bus_wr && clr_hit && (clr_idx == IDX_W'(k));
    mbx_word #(.W(DATA_W)) u_word (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_en (set_en_k),
      .clr_en (clr_en_k),
      .data   (bus_wdata),
      .val    (mb_val[k]),
      .pend   (mb_pend[k])
    );
  end

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    logic ctl_we_c;
    assign ctl_we_c = bus_wr && ctl_hit && (ctl_idx == CIDX_W'(c));
    mbx_core_route #(.MBN(MB_PER_CORE)) u_route (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl_we    (ctl_we_c),
      .ctl_wdata (bus_wdata[CTRL_W-1:0]),
      .pend      (mb_pend[c*MB_PER_CORE +: MB_PER_CORE]),
      .ctl_q     (ctl_q[c]),
      .irq       (irq_req[c]),
      .fiq       (fiq_req[c])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (clr_hit)      bus_rdata = mb_val[clr_idx];
      else if (ctl_hit) bus_rdata = DATA_W'(ctl_q[ctl_idx]);
    end
  end

  // R9
  one_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({set_hit, clr_hit, ctl_hit}));
  // R4
  set_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && set_hit |-> bus_rdata == '0);
  // R9
  stray_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && !clr_hit && !ctl_hit |-> bus_rdata == '0);
endmodule

// File: tb/mbx_bank_tb.sv
`timescale 1ns/1ps
module mbx_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  irq_req, fiq_req;

  int n_tests = 0;
  int n_fail  = 0;

  bit [31:0] mb_m  [16];
  bit [7:0]  ctl_m [4];

  always #2.5 clk = ~clk;

  mbx_bank u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_req(irq_req), .fiq_req(fiq_req)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    if (a[1:0] != 2'b00) return 32'h0;
    if (a >= 8'hC0) return mb_m[(a - 8'hC0) / 4];
    if (a >= 8'h50 && a < 8'h60) return {24'h0, ctl_m[(a - 8'h50) / 4]};
    return 32'h0;
  endfunction

  function automatic logic [3:0] exp_fiq();
    logic [3:0] r = '0;
    for (int c = 0; c < 4; c++)
      for (int n = 0; n < 4; n++)
        if (mb_m[4*c+n] != 0 && ctl_m[c][n+4]) r[c] = 1'b1;
    return r;
  endfunction

  function automatic logic [3:0] exp_irq();
    logic [3:0] r = '0;
    for (int c = 0; c < 4; c++)
      for (int n = 0; n < 4; n++)
        if (mb_m[4*c+n] != 0 && ctl_m[c][n] && !ctl_m[c][n+4]) r[c] = 1'b1;
    return r;
  endfunction

  task automatic do_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1 bus_wr = 1'b0;
    if (a[1:0] == 2'b00) begin
      if (a >= 8'hC0)                   mb_m[(a - 8'hC0) / 4] &= ~d;
      else if (a >= 8'h80)              mb_m[(a - 8'h80) / 4] |= d;
      else if (a >= 8'h50 && a < 8'h60) ctl_m[(a - 8'h50) / 4] = d[7:0];
    end
  endtask

  task automatic do_rd(input logic [7:0] a, input string req);
    logic [31:0] e;
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1;
    e = exp_read(a);
    chk(bus_rdata == e, req, bus_rdata, e);
    bus_rd = 1'b0;
  endtask

  task automatic chk_outs(input string req);
    logic [3:0] ei, ef;
    @(negedge clk);
    ei = exp_irq();
    ef = exp_fiq();
    chk(irq_req == ei, {req, " irq"}, {28'h0, irq_req}, {28'h0, ei});
    chk(fiq_req == ef, {req, " fiq"}, {28'h0, fiq_req}, {28'h0, ef});
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    chk_outs("R1");
    for (int k = 0; k < 16; k++) do_rd(8'(8'hC0 + 4*k), "R1 mailbox");
    for (int c = 0; c < 4; c++) do_rd(8'(8'h50 + 4*c), "R1 mask");

    // R2 OR accumulation into mailbox 5
    do_wr(8'h94, 32'h0000_000F);
    do_wr(8'h94, 32'h0000_00F0);
    do_rd(8'hD4, "R2");
    // R4 set window reads zero
    do_rd(8'h94, "R4 set window");
    // R3 clear selected bits
    do_wr(8'hD4, 32'h0000_003C);
    do_rd(8'hD4, "R3");
    // R6 mask width
    do_wr(8'h54, 32'hFFFF_FF12);
    do_rd(8'h54, "R6");
    // R5 R7 mailbox 5 is core 1 box 1, IRQ only on core 1
    do_wr(8'h54, 32'h0000_0002);
    chk_outs("R5 R7 R10");
    chk(irq_req == 4'b0010, "R5", {28'h0, irq_req}, 32'h2);
    // R8 FIQ enable overrides IRQ enable
    do_wr(8'h54, 32'h0000_0022);
    chk_outs("R8");
    chk(irq_req == 4'b0000 && fiq_req == 4'b0010, "R8 precedence",
        {24'h0, fiq_req, irq_req}, 32'h20);
    // R3 clearing the last bits drops the request
    do_wr(8'hD4, 32'hFFFF_FFFF);
    chk_outs("R3 R7");
    // R9 unaligned and unmapped
    do_wr(8'h81, 32'hFFFF_FFFF);
    do_rd(8'hC0, "R9 unaligned write");
    do_rd(8'hC1, "R9 unaligned read");
    do_wr(8'h60, 32'hFFFF_FFFF);
    do_rd(8'h60, "R9 unmapped read");
    do_rd(8'h00, "R9 unmapped read");
    chk_outs("R9");

    // Random mix
    for (int i = 0; i < 600; i++) begin
      int op;
      logic [7:0]  a;
      logic [31:0] d;
      op = $urandom_range(0, 4);
      d  = $urandom;
      case (op)
        0, 1: a = 8'(8'h80 + 4 * $urandom_range(0, 15));
        2: begin a = 8'(8'hC0 + 4 * $urandom_range(0, 15)); d = d & $urandom; end
        3: a = 8'(8'h50 + 4 * $urandom_range(0, 3));
        default: a = 8'($urandom);
      endcase
      do_wr(a, d);
      chk_outs("R7 R8 R10 random");
      do_rd(8'(8'hC0 + 4 * $urandom_range(0, 15)), "R2 R3 R4 random");
      if (i % 8 == 0) do_rd(8'($urandom), "R4 R6 R9 random");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule